// File: doc/BRIEF.md
# MSI Event Ring-Buffer Writer

This block sits between incoming message-signalled interrupt writes and system memory. Each message it accepts becomes one 16-byte record in a circular buffer in memory. It issues one write request for that record and then moves its write pointer forward. The buffer's 64-bit base address, its size (one of four powers of two) and the block's enables are programmed through a small word-addressed register port.

The host consumes records by reading the write offset and then writing its own read offset back. An interrupt line stays high while the enables are set and unread records remain. Optional full detection either holds off new messages or drops them and sets a sticky overflow flag.

Top module: `msi_ring_writer`

## Requirements
- R1: Register words by `reg_addr_i`: 0 control, 3 base address bits 63:32, 4 base address bits 31:0, 5 read offset (read/write), 6 write offset (read only); other addresses read zero. All registers reset to zero. Control fields: bit 0 enable, bit 1 full detect, bit 3 interrupt enable, bit 4 stop-on-full, bits 9:8 size code, bit 16 overflow.
- R2: The buffer size is 2^(15+code) bytes for size code 0..3. Read and write offsets read back masked to that size, with bits 3:0 always zero.
- R3: A message accepted while enabled and not dropped produces one write request. Its address is the 64-bit base plus the write offset. Data bits 31:0 hold the message number, byte 0 least significant (little-endian), and data bits 127:32 are zero.
- R4: A write request holds its address and data until `mem_req_ready_i` is high. The write offset advances by 0x10, modulo the buffer size, only in the cycle the request is accepted.
- R5: `msi_ready_o` is low while a write request is outstanding.
- R6: With enable clear, messages are accepted and discarded: no request is issued and the write offset is unchanged.
- R7: The buffer is full when the write offset plus 0x10, modulo the size, equals the read offset. If full detect and stop-on-full are both set and the buffer is full, `msi_ready_o` is low.
- R8: If full detect is set, stop-on-full is clear and the buffer is full, an accepted message is dropped and the sticky overflow bit is set. Writing control with bit 16 set clears the overflow bit, but a drop in the same cycle wins and the bit stays set.
- R9: `irq_o` is high exactly when enable and interrupt enable are set and the read offset differs from the write offset.
- R10: With full detect clear, messages are logged even when the buffer is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| msi_valid_i | input | 1 | Incoming message valid |
| msi_num_i | input | 32 | Interrupt number carried by the message |
| msi_ready_o | output | 1 | Message accepted when high together with valid |
| mem_req_valid_o | output | 1 | Entry write request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 64 | Byte address of the entry |
| mem_req_data_o | output | 128 | 16-byte entry contents |
| irq_o | output | 1 | Level interrupt: entries pending |

## Verification
The host's write to the read offset can land in the same cycle as memory accepting a request, which moves the write offset. The bench drives both in one cycle and then checks both offsets and the level of the interrupt line. A message dropped on a full buffer can also coincide with a host write that clears the overflow flag. The bench provokes this with a full buffer and stop-on-full clear, then checks that the flag stays set and that a later clear on its own removes it.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
  localparam int CODE_W     = 2;
  localparam int MIN_SHIFT  = 15;
  localparam int OFF_W      = MIN_SHIFT + (1 << CODE_W) - 1;
  localparam int ENTRY_B    = 16;
  localparam int REG_AW     = 3;
  localparam int REG_DW     = 32;
  localparam int MEM_AW     = 64;
  localparam int NUM_W      = 32;
  localparam int ENTRY_W    = ENTRY_B * 8;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL    = 3'h0,
    REG_BASE_HI = 3'h3,
    REG_BASE_LO = 3'h4,
    REG_RD_OFF  = 3'h5,
    REG_WR_OFF  = 3'h6
  } reg_sel_e;

  typedef struct packed {
    logic [CODE_W-1:0] size_code;
    logic              stop_en;
    logic              irq_en;
    logic              full_det_en;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int OFF_W_P = OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [REG_DW-1:0]  reg_wdata_i,
  output logic [REG_DW-1:0]  reg_rdata_o,
  output ctrl_t              ctrl_o,
  output logic [MEM_AW-1:0]  base_o,
  output logic [OFF_W_P-1:0] rd_off_o,
  input  logic [OFF_W_P-1:0] off_mask_i,
  input  logic [OFF_W_P-1:0] wr_off_i,
  input  logic               ovf_set_i
);
  localparam int HALF_AW = MEM_AW / 2;

  ctrl_t               ctrl_q;
  logic [HALF_AW-1:0]  base_hi_q, base_lo_q;
  logic [OFF_W_P-1:0]  rd_q;
  logic                ovf_q;
  logic                wr_ctrl, ovf_clr;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == REG_CTRL);
  assign ovf_clr = wr_ctrl && reg_wdata_i[16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
      rd_q      <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        REG_CTRL: begin
          ctrl_q.en          <= reg_wdata_i[0];
          ctrl_q.full_det_en <= reg_wdata_i[1];
          ctrl_q.irq_en      <= reg_wdata_i[3];
          ctrl_q.stop_en     <= reg_wdata_i[4];
          ctrl_q.size_code   <= reg_wdata_i[9:8];
        end
        REG_BASE_HI: base_hi_q <= reg_wdata_i[HALF_AW-1:0];
        REG_BASE_LO: base_lo_q <= reg_wdata_i[HALF_AW-1:0];
        REG_RD_OFF:  rd_q      <= reg_wdata_i[OFF_W_P-1:0];
        default: ;
      endcase
    end
  end

  // set has priority over a host clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (ovf_set_i) ovf_q <= 1'b1;
    else if (ovf_clr)   ovf_q <= 1'b0;
  end

  assign ctrl_o   = ctrl_q;
  assign base_o   = {base_hi_q, base_lo_q};
  assign rd_off_o = rd_q & off_mask_i;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL:    reg_rdata_o = {15'b0, ovf_q, 6'b0, ctrl_q.size_code, 3'b0,
                                  ctrl_q.stop_en, ctrl_q.irq_en, 1'b0,
                                  ctrl_q.full_det_en, ctrl_q.en};
      REG_BASE_HI: reg_rdata_o = base_hi_q;
      REG_BASE_LO: reg_rdata_o = base_lo_q;
      REG_RD_OFF:  reg_rdata_o = REG_DW'(rd_off_o);
      REG_WR_OFF:  reg_rdata_o = REG_DW'(wr_off_i);
      default:     reg_rdata_o = '0;
    endcase
  end

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !ovf_clr |=> ovf_q); // R8
  AST_OVF_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> ovf_q); // R8
endmodule

// File: rtl/msi_ring_offsets.sv
module msi_ring_offsets
  import msi_ring_pkg::*;
#(
  parameter int OFF_W_P   = OFF_W,
  parameter int CODE_W_P  = CODE_W,
  parameter int ENTRY_B_P = ENTRY_B
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CODE_W_P-1:0] size_code_i,
  input  logic [OFF_W_P-1:0]  rd_off_i,
  input  logic                adv_i,
  output logic [OFF_W_P-1:0]  off_mask_o,
  output logic [OFF_W_P-1:0]  wr_off_o,
  output logic                full_o,
  output logic                empty_o
);
  localparam int MAX_CODE = (1 << CODE_W_P) - 1;

  logic [OFF_W_P-1:0] span, wr_q, next_off;

  assign span       = {OFF_W_P{1'b1}} >> (MAX_CODE - int'(size_code_i));
  assign off_mask_o = span & ~OFF_W_P'(ENTRY_B_P - 1);
  assign wr_off_o   = wr_q & off_mask_o;
  assign next_off   = (wr_off_o + OFF_W_P'(ENTRY_B_P)) & off_mask_o;
  assign full_o     = (next_off == rd_off_i);
  assign empty_o    = (wr_off_o == rd_off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wr_q <= '0;
    else if (adv_i) wr_q <= next_off;
  end

  AST_FULL_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !empty_o); // R7
endmodule

// File: rtl/msi_ring_entry.sv
module msi_ring_entry
  import msi_ring_pkg::*;
#(
  parameter int ADDR_W_P  = MEM_AW,
  parameter int NUM_W_P   = NUM_W,
  parameter int ENTRY_W_P = ENTRY_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [ADDR_W_P-1:0]  addr_i,
  input  logic [NUM_W_P-1:0]   num_i,
  output logic                 valid_o,
  input  logic                 ready_i,
  output logic [ADDR_W_P-1:0]  addr_o,
  output logic [ENTRY_W_P-1:0] data_o,
  output logic                 done_o
);
  logic                pend_q;
  logic [ADDR_W_P-1:0] addr_q;
  logic [NUM_W_P-1:0]  num_q;

  assign done_o  = pend_q && ready_i;
  assign valid_o = pend_q;
  assign addr_o  = addr_q;
  assign data_o  = {{(ENTRY_W_P-NUM_W_P){1'b0}}, num_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      num_q  <= '0;
    end else if (load_i) begin
      pend_q <= 1'b1;
      addr_q <= addr_i;
      num_q  <= num_i;
    end else if (done_o) begin
      pend_q <= 1'b0;
    end
  end

  AST_LOAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !valid_o); // R5
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(data_o)); // R4
endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
  import msi_ring_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [REG_DW-1:0]  reg_wdata_i,
  output logic [REG_DW-1:0]  reg_rdata_o,
  input  logic               msi_valid_i,
  input  logic [NUM_W-1:0]   msi_num_i,
  output logic               msi_ready_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [MEM_AW-1:0]  mem_req_addr_o,
  output logic [ENTRY_W-1:0] mem_req_data_o,
  output logic               irq_o
);
  ctrl_t              ctrl;
  logic [MEM_AW-1:0]  base;
  logic [OFF_W-1:0]   rd_off, wr_off, off_mask;
  logic               full, empty, accept, log_en, drop_ovf, done, hold_off;

  msi_ring_regs #(.OFF_W_P(OFF_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .ctrl_o      (ctrl),
    .base_o      (base),
    .rd_off_o    (rd_off),
    .off_mask_i  (off_mask),
    .wr_off_i    (wr_off),
    .ovf_set_i   (drop_ovf)
  );

  msi_ring_offsets #(.OFF_W_P(OFF_W), .CODE_W_P(CODE_W), .ENTRY_B_P(ENTRY_B)) u_offs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .size_code_i (ctrl.size_code),
    .rd_off_i    (rd_off),
    .adv_i       (done),
    .off_mask_o  (off_mask),
    .wr_off_o    (wr_off),
    .full_o      (full),
    .empty_o     (empty)
  );

  // full-stop back-pressure only when full detection is armed
  assign hold_off    = ctrl.en && ctrl.full_det_en && ctrl.stop_en && full;
  assign msi_ready_o = !mem_req_valid_o && !hold_off;
  assign accept      = msi_valid_i && msi_ready_o;
  assign log_en      = accept && ctrl.en && !(ctrl.full_det_en && full);
  assign drop_ovf    = accept && ctrl.en && ctrl.full_det_en && full;

  msi_ring_entry #(.ADDR_W_P(MEM_AW), .NUM_W_P(NUM_W), .ENTRY_W_P(ENTRY_W)) u_entry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (log_en),
    .addr_i  (base + MEM_AW'(wr_off)),
    .num_i   (msi_num_i),
    .valid_o (mem_req_valid_o),
    .ready_i (mem_req_ready_i),
    .addr_o  (mem_req_addr_o),
    .data_o  (mem_req_data_o),
    .done_o  (done)
  );

  assign irq_o = ctrl.en && ctrl.irq_en && !empty;

  AST_STOP_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.en && ctrl.full_det_en && ctrl.stop_en && full |-> !msi_ready_o); // R7
  AST_BUSY_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !msi_ready_o); // R5
  AST_DISABLED_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !ctrl.en && !mem_req_valid_o |=> !mem_req_valid_o); // R6
  AST_WR_STABLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_valid_o && mem_req_ready_i) && !reg_wr_i |=> $stable(wr_off)); // R4
endmodule

// File: tb/msi_ring_writer_tb_top.sv
`timescale 1ns/1ps
module msi_ring_writer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msi_valid = 1'b0;
  logic [31:0]  msi_num = '0;
  logic         msi_ready;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  msi_ring_writer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .msi_valid_i(msi_valid), .msi_num_i(msi_num), .msi_ready_o(msi_ready),
    .mem_req_valid_o(mem_valid), .mem_req_ready_i(mem_ready),
    .mem_req_addr_o(mem_addr), .mem_req_data_o(mem_data), .irq_o(irq)
  );

  localparam int NVEC = 6;
  localparam logic [31:0] VEC_NUM  [NVEC] = '{32'h0000_0001, 32'h0000_00FF, 32'h1234_5678,
                                              32'hFFFF_FFFE, 32'h0000_0400, 32'h8000_0000};
  localparam int          VEC_WAIT [NVEC] = '{0, 1, 3, 0, 2, 5};
  localparam logic [63:0] BASE = 64'h0000_0001_ABCD_0000;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #0.5; d = reg_rdata;
  endtask

  // offer one message for one cycle; caller checks outcome at the following negedge
  task automatic offer(input logic [31:0] num);
    @(negedge clk); msi_valid = 1'b1; msi_num = num;
    @(negedge clk); msi_valid = 1'b0;
  endtask

  task automatic fast_log(input logic [31:0] num);
    offer(num);
    mem_ready = 1'b1;
    @(negedge clk); mem_ready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..: run hung");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [17:0] exp_off;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rreg(3'h0, rd); chk("R1 ctrl reset", rd, 0);
    rreg(3'h6, rd); chk("R1 wr off reset", rd, 0);
    chk("R9 irq reset", irq, 0);
    chk("R1 ready reset", msi_ready, 1);

    // R1 readback
    wreg(3'h3, BASE[63:32]);
    wreg(3'h4, BASE[31:0]);
    rreg(3'h3, rd); chk("R1 base hi", rd, BASE[63:32]);
    rreg(3'h4, rd); chk("R1 base lo", rd, BASE[31:0]);
    rreg(3'h2, rd); chk("R1 unused addr", rd, 0);
    wreg(3'h0, 32'h0000_031B);
    rreg(3'h0, rd); chk("R1 ctrl fields", rd, 32'h0000_031B);

    // R2 masking of offsets by size code
    wreg(3'h5, 32'h0001_FFFF);
    rreg(3'h5, rd); chk("R2 rd mask 256K", rd, 32'h0001_FFF0);
    wreg(3'h0, 32'h0000_0009);
    rreg(3'h5, rd); chk("R2 rd mask 32K", rd, 32'h0000_7FF0);
    wreg(3'h0, 32'h0000_0109);
    wreg(3'h5, 32'h0);

    // R3/R4/R5 vector walk
    for (int i = 0; i < NVEC; i++) begin
      offer(VEC_NUM[i]);
      chk("R3 req valid", mem_valid, 1);
      chk("R3 req addr", mem_addr, BASE + 64'(i * 16));
      chk("R3 req data", mem_data, {96'b0, VEC_NUM[i]});
      chk("R3 byte0 lsb", mem_data[7:0], VEC_NUM[i][7:0]);
      chk("R5 busy not ready", msi_ready, 0);
      for (int w = 0; w < VEC_WAIT[i]; w++) begin
        @(negedge clk);
        chk("R4 hold addr", mem_addr, BASE + 64'(i * 16));
        rreg(3'h6, rd); chk("R4 no advance", rd, 32'(i * 16));
      end
      mem_ready = 1'b1;
      @(negedge clk); mem_ready = 1'b0;
      chk("R4 released", mem_valid, 0);
      rreg(3'h6, rd); chk("R4 advance", rd, 32'((i + 1) * 16));
      chk("R9 irq pending", irq, 1);
    end

    // same cycle: host read-offset write and memory acceptance
    offer(32'h55);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'h5; reg_wdata = 32'h70; mem_ready = 1'b1;
    @(negedge clk); reg_wr = 1'b0; mem_ready = 1'b0;
    rreg(3'h6, rd); chk("R4 wr after coincide", rd, 32'h70);
    rreg(3'h5, rd); chk("R1 rd after coincide", rd, 32'h70);
    chk("R9 irq empty", irq, 0);

    // R9 irq gated by irq enable
    fast_log(32'h66);
    chk("R9 pending", irq, 1);
    wreg(3'h0, 32'h0000_0101);
    chk("R9 irq disabled", irq, 0);

    // R6 disabled: discard
    wreg(3'h0, 32'h0000_0100);
    offer(32'h77);
    chk("R6 no request", mem_valid, 0);
    rreg(3'h6, rd); chk("R6 wr unchanged", rd, 32'h80);

    // full handling with 32 KB ring
    do_reset();
    wreg(3'h0, 32'h0000_001B);
    for (int k = 0; k < 2047; k++) fast_log(k);
    rreg(3'h6, rd); chk("R7 wr at last slot", rd, 32'h7FF0);
    @(negedge clk); msi_valid = 1'b1; msi_num = 32'hAA; #0.5;
    chk("R7 stop holds off", msi_ready, 0);
    @(negedge clk); msi_valid = 1'b0;
    chk("R7 no request", mem_valid, 0);

    // R8 drop with overflow, and set-beats-clear
    wreg(3'h0, 32'h0000_000B);
    offer(32'hBB);
    chk("R8 dropped", mem_valid, 0);
    rreg(3'h0, rd); chk("R8 ovf set", rd[16], 1);
    rreg(3'h6, rd); chk("R8 wr unchanged", rd, 32'h7FF0);
    @(negedge clk); msi_valid = 1'b1; msi_num = 32'hCC;
    reg_wr = 1'b1; reg_addr = 3'h0; reg_wdata = 32'h0001_000B;
    @(negedge clk); msi_valid = 1'b0; reg_wr = 1'b0;
    rreg(3'h0, rd); chk("R8 set wins over clear", rd[16], 1);
    wreg(3'h0, 32'h0001_000B);
    rreg(3'h0, rd); chk("R8 ovf cleared", rd[16], 0);

    // R10 full detect off: log and wrap
    wreg(3'h0, 32'h0000_0009);
    offer(32'hDD);
    chk("R10 logged when full", mem_valid, 1);
    chk("R10 addr last slot", mem_addr, BASE_RESET_ADDR(18'h7FF0));
    mem_ready = 1'b1;
    @(negedge clk); mem_ready = 1'b0;
    rreg(3'h6, rd); exp_off = '0; chk("R4 wrap to zero", rd, 32'(exp_off));
    chk("R9 irq when equal", irq, 0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  // base registers are zero after the mid-run reset
  function automatic logic [63:0] BASE_RESET_ADDR(input logic [17:0] off);
    return 64'(off);
  endfunction
endmodule